// File: doc/BRIEF.md
# Serial Management Slave with Preamble Suppression

This block is the receiving end of a two-wire serial management link: a slow clock (`mdc`) from the management master and a bidirectional data line, split here into an input and an output with an enable. The block oversamples both wires with the system clock, finds the rising edges of `mdc`, and decodes each frame. A frame is a start pattern, a two-bit operation code, a five-bit station address, a five-bit register index, a two-bit turnaround and sixteen data bits. When the station address matches `phy_addr`, a write frame produces a one-cycle write strobe and a read frame produces a one-cycle read strobe. The block then shifts the returned register word back onto the line.

The block keeps a synchronisation flag. After reset it accepts a frame only after at least 32 consecutive ones on the data line. Once synchronised, it accepts frames with no leading ones at all. An unknown operation code or a malformed write turnaround clears the flag, and a full run of 32 ones is then needed again. A pulse on `soft_rst` from the register bank opens a hold-off window of `HOLD_CYCLES` system clocks, and frames that complete during that window are parsed but ignored.

Top module: `mdio_slave`

## Requirements
- R1: After `rst_n` is released, `mdio_oe`, `rd_req` and `wr_en` are low and the block is unsynchronised.
- R2: While unsynchronised, a frame is accepted only if at least 32 consecutive one bits, sampled on `mdc` rising edges, come before its start bits `0` then `1`. A run of 31 ones is not enough, and the frame is ignored.
- R3: Once synchronised, a frame that starts directly with `0`,`1`, with no leading ones, is accepted.
- R4: Operation codes `10` (read) and `01` (write) are valid, each sent first bit first. Codes `00` and `11` abort the frame and clear synchronisation.
- R5: On a write, the turnaround must be `1` then `0`. Any other pair aborts the frame without a write strobe and clears synchronisation.
- R6: A valid matched write raises `wr_en` for exactly one system clock, after the last data bit. At that moment `reg_addr` holds the register index and `wr_data` holds the 16 data bits, sent MSB first. `rd_req` and `wr_en` are never high in the same cycle.
- R7: On a valid matched read, `rd_req` pulses for one cycle with `reg_addr` valid once the address phase ends. The line stays released for the first turnaround bit and is driven to `0` for the second. The 16 bits of `rd_data` then go out MSB first, each updated after an `mdc` rising edge. The line is released after the last bit, and the first driven value is always `0`.
- R8: A frame whose station address differs from `phy_addr` causes no strobe and is never driven. Synchronisation is kept.
- R9: A frame whose address phase or data phase ends within `HOLD_CYCLES` clocks after a `soft_rst` pulse causes no strobe and is not driven.
- R10: The register index is 5 bits wide, sent MSB first, and registers 0 and 31 are both reachable for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `mdc` |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the master |
| mdio_in | input | 1 | Data line as seen at the pad |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| phy_addr | input | 5 | Station address this slave answers to |
| soft_rst | input | 1 | One-cycle pulse when software reset is issued |
| reg_addr | output | 5 | Register index of the current access |
| rd_req | output | 1 | One-cycle read strobe |
| rd_data | input | 16 | Register word, valid from `rd_req` until the turnaround ends |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Word to be written |

## Verification
The hold-off timer and frame completion can coincide. A `soft_rst` pulse is issued just before a preamble-less write, so the write's address phase ends inside the window. The bench then checks that no strobe appears and that the register holds its old value once the window has closed. Loss of synchronisation and station-address filtering can act on the same frame: an aborting opcode or turnaround is judged by sending a preamble-less frame right after it, which must be ignored, and then a frame with full preamble, which must be accepted. Reads compare the sampled turnaround and data bits against a scoreboard of words written earlier.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        S_HUNT  = 3'd0,
        S_START = 3'd1,
        S_OP    = 3'd2,
        S_ADDR  = 3'd3,
        S_TA    = 3'd4,
        S_DATA  = 3'd5
    } eng_st_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
endpackage

// File: rtl/mdc_sampler.sv
module mdc_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic rise,
    output logic bit_s
);
    typedef struct packed {
        logic [SYNC-1:0] clk_sr;
        logic [SYNC-1:0] dat_sr;
        logic            clk_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.clk_sr   = {smp_q.clk_sr[SYNC-2:0], mdc};
        smp_d.dat_sr   = {smp_q.dat_sr[SYNC-2:0], mdio_in};
        smp_d.clk_prev = smp_q.clk_sr[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign rise  = smp_q.clk_sr[SYNC-1] & ~smp_q.clk_prev;
    assign bit_s = smp_q.dat_sr[SYNC-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_CYCLES = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int TW = $clog2(HOLD_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = TW'(HOLD_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int AW      = 5,
    parameter int DW      = 16,
    parameter int PRE_LEN = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_vld,
    input  logic          bit_in,
    input  logic [AW-1:0] phy_addr,
    input  logic          hold,
    input  logic [DW-1:0] rd_data,
    output logic          mdio_out,
    output logic          mdio_oe,
    output logic [AW-1:0] reg_addr,
    output logic          rd_req,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2((DW > 2*AW) ? DW : 2*AW);
    localparam int PW = $clog2(PRE_LEN + 1);

    typedef struct packed {
        eng_st_t       st;
        logic [CW-1:0] cnt;
        logic [PW-1:0] pre;
        logic          synced;
        logic          is_rd;
        logic          match;
        logic [DW-1:0] sh;
        logic [AW-1:0] ra;
        logic [DW-1:0] wd;
        logic          oe;
        logic          out;
        logic          rd_req;
        logic          wr_en;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [1:0]      opc;
    logic [2*AW-1:0] fld;

    always_comb begin
        eng_d        = eng_q;
        eng_d.rd_req = 1'b0;
        eng_d.wr_en  = 1'b0;
        opc          = {eng_q.sh[0], bit_in};
        fld          = {eng_q.sh[2*AW-2:0], bit_in};
        if (bit_vld) begin
            case (eng_q.st)
                S_HUNT: begin
                    if (bit_in) begin
                        if (eng_q.pre != PW'(PRE_LEN)) eng_d.pre = eng_q.pre + 1'b1;
                    end else if (eng_q.synced || eng_q.pre == PW'(PRE_LEN)) begin
                        eng_d.st     = S_START;
                        eng_d.synced = 1'b1;
                        eng_d.pre    = '0;
                    end else begin
                        eng_d.pre = '0;
                    end
                end
                S_START: begin
                    eng_d.cnt = '0;
                    eng_d.st  = bit_in ? S_OP : S_HUNT;
                end
                S_OP: begin
                    eng_d.sh = {eng_q.sh[DW-2:0], bit_in};
                    if (eng_q.cnt == CW'(1)) begin
                        eng_d.cnt = '0;
                        if (opc == OPC_READ || opc == OPC_WRITE) begin
                            eng_d.is_rd = (opc == OPC_READ);
                            eng_d.st    = S_ADDR;
                        end else begin
                            eng_d.synced = 1'b0;
                            eng_d.pre    = '0;
                            eng_d.st     = S_HUNT;
                        end
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                S_ADDR: begin
                    eng_d.sh = {eng_q.sh[DW-2:0], bit_in};
                    if (eng_q.cnt == CW'(2*AW-1)) begin
                        eng_d.match  = (fld[2*AW-1:AW] == phy_addr) && !hold;
                        eng_d.ra     = fld[AW-1:0];
                        eng_d.rd_req = eng_q.is_rd && (fld[2*AW-1:AW] == phy_addr) && !hold;
                        eng_d.cnt    = '0;
                        eng_d.st     = S_TA;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                S_TA: begin
                    if (eng_q.is_rd) begin
                        if (eng_q.cnt == '0) begin
                            if (eng_q.match) begin
                                eng_d.oe  = 1'b1;
                                eng_d.out = 1'b0;
                                eng_d.sh  = rd_data;
                            end
                            eng_d.cnt = CW'(1);
                        end else begin
                            if (eng_q.match) eng_d.out = eng_q.sh[DW-1];
                            eng_d.sh  = {eng_q.sh[DW-2:0], 1'b0};
                            eng_d.cnt = '0;
                            eng_d.st  = S_DATA;
                        end
                    end else if (eng_q.cnt == '0) begin
                        if (!bit_in) begin
                            eng_d.synced = 1'b0;
                            eng_d.pre    = '0;
                            eng_d.st     = S_HUNT;
                        end else begin
                            eng_d.cnt = CW'(1);
                        end
                    end else if (bit_in) begin
                        eng_d.synced = 1'b0;
                        eng_d.pre    = '0;
                        eng_d.st     = S_HUNT;
                    end else begin
                        eng_d.cnt = '0;
                        eng_d.st  = S_DATA;
                    end
                end
                S_DATA: begin
                    if (eng_q.is_rd) begin
                        if (eng_q.cnt == CW'(DW-1)) begin
                            eng_d.oe  = 1'b0;
                            eng_d.out = 1'b0;
                            eng_d.pre = '0;
                            eng_d.st  = S_HUNT;
                        end else begin
                            if (eng_q.match) eng_d.out = eng_q.sh[DW-1];
                            eng_d.sh  = {eng_q.sh[DW-2:0], 1'b0};
                            eng_d.cnt = eng_q.cnt + 1'b1;
                        end
                    end else begin
                        eng_d.sh = {eng_q.sh[DW-2:0], bit_in};
                        if (eng_q.cnt == CW'(DW-1)) begin
                            eng_d.wd    = {eng_q.sh[DW-2:0], bit_in};
                            eng_d.wr_en = eng_q.match && !hold;
                            eng_d.pre   = '0;
                            eng_d.st    = S_HUNT;
                        end else begin
                            eng_d.cnt = eng_q.cnt + 1'b1;
                        end
                    end
                end
                default: eng_d.st = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mdio_out = eng_q.out;
    assign mdio_oe  = eng_q.oe;
    assign reg_addr = eng_q.ra;
    assign rd_req   = eng_q.rd_req;
    assign wr_en    = eng_q.wr_en;
    assign wr_data  = eng_q.wd;

    // R7: the first value put on the line is the low turnaround bit
    p_first_drive_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.oe) |-> !eng_q.out);

    // R8: the line is only ever driven by a synchronised engine
    p_drive_when_synced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.oe |-> eng_q.synced);

    // R7: once a read strobe is issued, the line stays released until the next bit edge
    p_rdreq_line_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.rd_req |-> !eng_q.oe);
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
    parameter int AW          = 5,
    parameter int DW          = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC        = 2,
    parameter int HOLD_CYCLES = 150
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdc,
    input  logic          mdio_in,
    output logic          mdio_out,
    output logic          mdio_oe,
    input  logic [AW-1:0] phy_addr,
    input  logic          soft_rst,
    output logic [AW-1:0] reg_addr,
    output logic          rd_req,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);
    logic bit_vld;
    logic bit_s;
    logic hold;

    mdc_sampler #(.SYNC(SYNC)) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .rise    (bit_vld),
        .bit_s   (bit_s)
    );

    hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (soft_rst),
        .active (hold)
    );

    mdio_frame_engine #(.AW(AW), .DW(DW), .PRE_LEN(PRE_LEN)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_s),
        .phy_addr (phy_addr),
        .hold     (hold),
        .rd_data  (rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .reg_addr (reg_addr),
        .rd_req   (rd_req),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    // R9: no register access while the hold-off timer runs
    p_hold_blocks_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!wr_en && !rd_req));

    // R6: read and write strobes exclude each other
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_req));

    // R6: a write strobe lasts a single cycle
    p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: tb/test_mdio_slave.sv
module test_mdio_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int HOLD       = 300;
    localparam logic [4:0] MY_PHY = 5'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b1;
    logic        m_oe = 1'b0;
    logic        m_val = 1'b1;
    logic        soft_rst = 1'b0;
    logic        mdio_out, mdio_oe, rd_req, wr_en;
    logic [4:0]  reg_addr;
    logic [15:0] rd_data, wr_data;
    logic        bus;
    logic [15:0] bank [32];

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [4:0] last_rd = '0;
    logic [20:0] wq[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus     = mdio_oe ? mdio_out : (m_oe ? m_val : 1'b1);
    assign rd_data = bank[reg_addr];

    mdio_slave #(.HOLD_CYCLES(HOLD)) i_mdio_slave (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(bus),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_addr(MY_PHY),
        .soft_rst(soft_rst), .reg_addr(reg_addr), .rd_req(rd_req),
        .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes and compares with what the design produces
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            wr_cnt++;
            bank[reg_addr] <= wr_data;
            if (wq.size() == 0) begin
                chk(1'b0, "R6 unexpected write", {11'd0, reg_addr, wr_data}, 32'd0);
            end else begin
                logic [20:0] e;
                e = wq.pop_front();
                chk({reg_addr, wr_data} == e, "R6 write addr/data", {11'd0, reg_addr, wr_data}, {11'd0, e});
            end
        end
        if (rst_n && rd_req) begin
            rd_cnt++;
            last_rd = reg_addr;
        end
    end

    task automatic slot(input logic drv, input logic v, output logic s);
        @(negedge clk);
        m_oe = drv; m_val = v; mdc = 1'b0;
        repeat (HALF-1) @(negedge clk);
        s = bus;
        mdc = 1'b1;
        repeat (HALF-1) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        logic s;
        for (int i = n-1; i >= 0; i--) slot(1'b1, v[i], s);
    endtask

    task automatic preamble(input int n);
        logic s;
        for (int i = 0; i < n; i++) slot(1'b1, 1'b1, s);
    endtask

    // write-style frame with explicit opcode and turnaround; pushes expectation when asked
    task automatic wframe(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [1:0] ta, input logic [15:0] d, input bit expect_wr);
        if (expect_wr) wq.push_back({ra, d});
        send_bits(2, 2'b01);
        send_bits(2, op);
        send_bits(5, phy);
        send_bits(5, ra);
        send_bits(2, ta);
        send_bits(16, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic rframe(input logic [4:0] phy, input logic [4:0] ra,
                          output logic [1:0] ta, output logic [15:0] d);
        logic s;
        send_bits(2, 2'b01);
        send_bits(2, 2'b10);
        send_bits(5, phy);
        send_bits(5, ra);
        for (int i = 1; i >= 0; i--) begin slot(1'b0, 1'b1, s); ta[i] = s; end
        for (int i = 15; i >= 0; i--) begin slot(1'b0, 1'b1, s); d[i] = s; end
        repeat (4) @(negedge clk);
    endtask

    task automatic read_expect(input logic [4:0] ra, input logic [15:0] exp, input string tag);
        logic [1:0] ta; logic [15:0] d; int rc;
        rc = rd_cnt;
        rframe(MY_PHY, ra, ta, d);
        chk(ta == 2'b10, {tag, " turnaround"}, {30'd0, ta}, 32'h2);
        chk(d == exp, {tag, " data"}, {16'd0, d}, {16'd0, exp});
        chk(rd_cnt == rc + 1 && last_rd == ra, {tag, " rd_req"}, {27'd0, last_rd}, {27'd0, ra});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wc;
        logic [1:0] ta; logic [15:0] d;
        for (int i = 0; i < 32; i++) bank[i] = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mdio_oe && !wr_en && !rd_req, "R1 reset outputs", {29'd0, mdio_oe, wr_en, rd_req}, 32'd0);

        // R2: no preamble while unsynced, then only 31 ones
        wc = wr_cnt;
        wframe(2'b01, MY_PHY, 5'd3, 2'b10, 16'h1110, 0);
        chk(wr_cnt == wc, "R2 no-preamble frame ignored", wr_cnt, wc);
        preamble(31);
        wframe(2'b01, MY_PHY, 5'd3, 2'b10, 16'h2220, 0);
        chk(wr_cnt == wc, "R2 31-bit preamble ignored", wr_cnt, wc);

        // R2/R6: full preamble accepted
        preamble(32);
        wframe(2'b01, MY_PHY, 5'd3, 2'b10, 16'h3333, 1);
        chk(wr_cnt == wc + 1, "R2 32-bit preamble accepted", wr_cnt, wc + 1);

        // R3/R10: suppressed preamble, highest register
        wframe(2'b01, MY_PHY, 5'd31, 2'b10, 16'hABCD, 1);
        chk(wr_cnt == wc + 2, "R3 preamble-less write accepted", wr_cnt, wc + 2);
        read_expect(5'd31, 16'hABCD, "R7 R10 read reg31");

        // R10: lowest register
        wframe(2'b01, MY_PHY, 5'd0, 2'b10, 16'h5A5A, 1);
        read_expect(5'd0, 16'h5A5A, "R10 read reg0");

        // R8: mismatched station address
        wc = wr_cnt;
        wframe(2'b01, 5'h06, 5'd3, 2'b10, 16'hDEAD, 0);
        chk(wr_cnt == wc, "R8 foreign write ignored", wr_cnt, wc);
        begin
            int rc;
            rc = rd_cnt;
            rframe(5'h06, 5'd3, ta, d);
            chk(ta == 2'b11 && d == 16'hFFFF, "R8 foreign read not driven", {14'd0, ta, d}, 32'h3FFFF);
            chk(rd_cnt == rc, "R8 foreign read no strobe", rd_cnt, rc);
        end
        read_expect(5'd3, 16'h3333, "R8 sync kept after foreign frame");

        // R4: invalid opcode drops sync
        wframe(2'b11, MY_PHY, 5'd0, 2'b10, 16'h0000, 0);
        wc = wr_cnt;
        wframe(2'b01, MY_PHY, 5'd4, 2'b10, 16'h1230, 0);
        chk(wr_cnt == wc, "R4 unsynced after bad opcode", wr_cnt, wc);
        preamble(32);
        wframe(2'b01, MY_PHY, 5'd4, 2'b10, 16'h4444, 1);
        chk(wr_cnt == wc + 1, "R4 resync with preamble", wr_cnt, wc + 1);
        read_expect(5'd4, 16'h4444, "R4 readback");

        // R5: bad write turnaround drops sync and discards write
        wc = wr_cnt;
        wframe(2'b01, MY_PHY, 5'd4, 2'b11, 16'h00F0, 0);
        chk(wr_cnt == wc, "R5 bad turnaround write dropped", wr_cnt, wc);
        wframe(2'b01, MY_PHY, 5'd4, 2'b10, 16'h7770, 0);
        chk(wr_cnt == wc, "R5 unsynced after bad turnaround", wr_cnt, wc);
        preamble(32);
        read_expect(5'd4, 16'h4444, "R5 register unchanged");

        // R9: soft reset hold-off
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        wc = wr_cnt;
        wframe(2'b01, MY_PHY, 5'd5, 2'b10, 16'h9990, 0);
        chk(wr_cnt == wc, "R9 write in hold-off ignored", wr_cnt, wc);
        repeat (HOLD + 50) @(negedge clk);
        read_expect(5'd5, 16'h0000, "R9 register untouched");
        wframe(2'b01, MY_PHY, 5'd5, 2'b10, 16'h6660, 1);
        read_expect(5'd5, 16'h6660, "R9 access after hold-off");

        repeat (10) @(negedge clk);
        chk(wq.size() == 0, "R6 all expected writes seen", wq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule